// File: doc/BRIEF.md
# Control-Opcode Sequencer with Return Stack

This block runs the control instructions of a small controller core that take no operands. These instructions are the idle opcode, the copy from the accumulator into the timer/prescaler configuration register, and the return from an interrupt handler. Every other 14-bit opcode only moves the program counter forward. An instruction cycle has four quarter phases. The block advances one quarter on each clock edge at which the quarter enable is high, and holds all of its state while that enable is low.

The block has an eight-entry circular stack of 13-bit return addresses. A push request stands in for interrupt entry: it stores an address and clears the global interrupt enable. The interrupt return is executed over two instruction cycles. In the first cycle the interrupt enable is set and the stack is popped into the program counter. The second cycle is dead. While it runs, a flush output is high and the opcode presented during that cycle is thrown away.

Top module: `ctl_seq_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `pc` is 0, `gie` is 0, `option_reg` is 8'hFF, `flush` is 0, and the stack pointer is 0. The first active quarter after reset is Q1.
- R2: Each clock edge with `q_en` high advances the quarter phase Q1→Q2→Q3→Q4→Q1. An edge with `q_en` low changes no output and no internal state.
- R3: The opcode is captured at the Q1 edge. Any opcode equal to 14'h0000 after masking with 14'h3F9F (bits 6 and 5 ignored) is an idle instruction. It raises `pc` by one at the Q4 edge and leaves `option_reg` and `gie` unchanged.
- R4: Opcode 14'h0062 copies the `wreg` value present at the Q4 edge into `option_reg` and raises `pc` by one at that same edge.
- R5: Every opcode other than the idle pattern, 14'h0062 and 14'h0009 raises `pc` by one at the Q4 edge. It does not touch `option_reg` or `gie`.
- R6: Opcode 14'h0009 (interrupt return) sets `gie` at the Q3 edge of its first cycle.
- R7: At the Q4 edge of the interrupt return, `pc` takes the most recently pushed address and the stack pointer steps back by one.
- R8: For the whole instruction cycle after the interrupt return, `flush` is high. The opcode captured in that cycle has no effect: `pc`, `option_reg` and `gie` hold, and `flush` falls at that cycle's Q4 edge.
- R9: `push_req` is sampled only at a Q1 edge. When high, it stores `push_addr` on the stack and clears `gie`.
- R10: The stack holds 8 entries and its pointer wraps modulo 8 on both push and pop without any indication. A ninth push overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_en | input | 1 | Quarter-phase enable; one quarter per high edge |
| instr | input | 14 | Fetched instruction word, captured in Q1 |
| wreg | input | 8 | Accumulator value, used at Q4 |
| push_req | input | 1 | Return-address push request, taken at Q1 |
| push_addr | input | 13 | Address to push |
| pc | output | 13 | Program counter |
| option_reg | output | 8 | Timer/prescaler configuration register |
| gie | output | 1 | Global interrupt enable |
| flush | output | 1 | High during the discarded cycle after an interrupt return |

## Verification
Every output is a register, so each result appears one clock after the enabled edge of its quarter. Push effects and opcode capture appear after Q1, the enable set after Q3, and the counter, configuration and stack pop after Q4. The flush flag is high across the four quarters that follow. The bench drives inputs on the falling edge and moves its behavioural model one step just after each rising edge. It compares all four outputs on the next falling edge, so any quarter in which the design acts early or late shows up as a mismatch on that cycle. Idle clocks are placed between quarters to confirm that nothing moves while the enable is low.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qphase_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_OPTLD  = 2'd1,
        OP_RETI   = 2'd2,
        OP_OTHER  = 2'd3
    } opkind_e;

    localparam int unsigned OPC_W = 14;
    localparam logic [OPC_W-1:0] IDLE_MASK  = 14'h3F9F;
    localparam logic [OPC_W-1:0] IDLE_CODE  = 14'h0000;
    localparam logic [OPC_W-1:0] OPTLD_CODE = 14'h0062;
    localparam logic [OPC_W-1:0] RETI_CODE  = 14'h0009;

endpackage

// File: rtl/qphase_seq.sv
module qphase_seq
    import ctl_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    q_en,
    output qphase_e phase
);
    qphase_e phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (q_en) begin
            phase_d = qphase_e'(phase_q + 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_Q1;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_seq_pkg::*;
#(
    parameter int unsigned INSTR_W = OPC_W
) (
    input  logic [INSTR_W-1:0] instr,
    output opkind_e            kind
);
    logic is_idle, is_optld, is_reti;

    always_comb begin
        is_idle  = ((instr & INSTR_W'(IDLE_MASK)) == INSTR_W'(IDLE_CODE));
        is_optld = (instr == INSTR_W'(OPTLD_CODE));
        is_reti  = (instr == INSTR_W'(RETI_CODE));
        if (is_idle) begin
            kind = OP_IDLE;
        end else if (is_optld) begin
            kind = OP_OPTLD;
        end else if (is_reti) begin
            kind = OP_RETI;
        end else begin
            kind = OP_OTHER;
        end
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop,
    output logic [ADDR_W-1:0] tos
);
    localparam int unsigned SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp_d, sp_q, sp_dec;

    always_comb begin
        sp_dec = sp_q - SP_W'(1);
        sp_d   = sp_q;
        if (push && !pop) begin
            sp_d = sp_q + SP_W'(1);
        end else if (pop && !push) begin
            sp_d = sp_dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[sp_q] <= push_addr;
        end
    end

    assign tos = mem[sp_dec];
endmodule

// File: rtl/ctl_seq_top.sv
module ctl_seq_top
    import ctl_seq_pkg::*;
#(
    parameter int unsigned PC_W        = 13,
    parameter int unsigned W_W         = 8,
    parameter int unsigned INSTR_W     = 14,
    parameter int unsigned STACK_DEPTH = 8,
    parameter logic [W_W-1:0] OPT_RST  = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_en,
    input  logic [INSTR_W-1:0] instr,
    input  logic [W_W-1:0]     wreg,
    input  logic               push_req,
    input  logic [PC_W-1:0]    push_addr,
    output logic [PC_W-1:0]    pc,
    output logic [W_W-1:0]     option_reg,
    output logic               gie,
    output logic               flush
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [W_W-1:0]  opt;
        logic            gie;
        logic            flush;
        opkind_e         kind;
    } seq_state_t;

    seq_state_t      s_d, s_q;
    qphase_e         phase_q;
    opkind_e         dec_kind;
    logic [PC_W-1:0] tos;
    logic            at_q1, at_q3, at_q4;
    logic            do_push, do_pop;

    qphase_seq u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .q_en  (q_en),
        .phase (phase_q)
    );

    ctl_decode #(.INSTR_W(INSTR_W)) u_dec (
        .instr (instr),
        .kind  (dec_kind)
    );

    ret_stack #(.DEPTH(STACK_DEPTH), .ADDR_W(PC_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_addr (push_addr),
        .pop       (do_pop),
        .tos       (tos)
    );

    always_comb begin
        s_d     = s_q;
        at_q1   = q_en && (phase_q == PH_Q1);
        at_q3   = q_en && (phase_q == PH_Q3);
        at_q4   = q_en && (phase_q == PH_Q4);
        do_push = at_q1 && push_req;
        do_pop  = at_q4 && !s_q.flush && (s_q.kind == OP_RETI);

        if (at_q1) begin
            s_d.kind = s_q.flush ? OP_IDLE : dec_kind;
        end
        if (do_push) begin
            s_d.gie = 1'b0;
        end
        if (at_q3 && !s_q.flush && (s_q.kind == OP_RETI)) begin
            s_d.gie = 1'b1;
        end
        if (at_q4) begin
            if (s_q.flush) begin
                s_d.flush = 1'b0;
            end else begin
                unique case (s_q.kind)
                    OP_RETI: begin
                        s_d.pc    = tos;
                        s_d.flush = 1'b1;
                    end
                    OP_OPTLD: begin
                        s_d.opt = wreg;
                        s_d.pc  = s_q.pc + PC_W'(1);
                    end
                    default: begin
                        s_d.pc = s_q.pc + PC_W'(1);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pc    <= '0;
            s_q.opt   <= OPT_RST;
            s_q.gie   <= 1'b0;
            s_q.flush <= 1'b0;
            s_q.kind  <= OP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc         = s_q.pc;
    assign option_reg = s_q.opt;
    assign gie        = s_q.gie;
    assign flush      = s_q.flush;
endmodule

// File: rtl/ctl_seq_chk.sv
module ctl_seq_chk
    import ctl_seq_pkg::*;
#(
    parameter int unsigned PC_W = 13,
    parameter int unsigned W_W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            q_en,
    input logic            push_req,
    input qphase_e         phase,
    input logic [PC_W-1:0] pc,
    input logic [W_W-1:0]  option_reg,
    input logic            gie,
    input logic            flush
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_en |=> ($stable(pc) && $stable(option_reg) && $stable(gie) && $stable(flush)));

    assert_pc_q4_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_en && phase == PH_Q4) |=> $stable(pc));

    assert_opt_q4_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_en && phase == PH_Q4) |=> $stable(option_reg));

    assert_gie_set_q3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> ($past(q_en) && $past(phase) == PH_Q3));

    assert_flush_q4_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_en && phase == PH_Q4) |=> $stable(flush));

    assert_push_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_en && phase == PH_Q1 && push_req) |=> !gie);
endmodule

bind ctl_seq_top ctl_seq_chk #(.PC_W(PC_W), .W_W(W_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_en       (q_en),
    .push_req   (push_req),
    .phase      (phase_q),
    .pc         (pc),
    .option_reg (option_reg),
    .gie        (gie),
    .flush      (flush)
);

// File: tb/ctl_seq_top_tb_top.sv
`timescale 1ns/1ps
module ctl_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_en = 1'b0;
    logic [13:0] instr = '0;
    logic [7:0]  wreg = '0;
    logic        push_req = 1'b0;
    logic [12:0] push_addr = '0;
    logic [12:0] pc;
    logic [7:0]  option_reg;
    logic        gie;
    logic        flush;

    always #10 clk = ~clk;

    ctl_seq_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_en       (q_en),
        .instr      (instr),
        .wreg       (wreg),
        .push_req   (push_req),
        .push_addr  (push_addr),
        .pc         (pc),
        .option_reg (option_reg),
        .gie        (gie),
        .flush      (flush)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_ph = 0, m_pc = 0, m_opt = 255, m_gie = 0, m_flush = 0, m_kind = 0, m_sp = 0;
    int stk[8];

    function automatic int classify(input logic [13:0] w);
        if ((w & 14'h3F9F) == 14'h0000) return 0;
        if (w == 14'h0062) return 1;
        if (w == 14'h0009) return 2;
        return 3;
    endfunction

    task automatic model_step();
        if (rst_n && q_en) begin
            case (m_ph)
                0: begin
                    if (push_req) begin
                        stk[m_sp] = int'(push_addr);
                        m_sp = (m_sp + 1) % 8;
                        m_gie = 0;
                    end
                    m_kind = m_flush ? 0 : classify(instr);
                end
                2: if (m_kind == 2 && m_flush == 0) m_gie = 1;
                3: begin
                    if (m_flush != 0) m_flush = 0;
                    else if (m_kind == 2) begin
                        m_sp = (m_sp + 7) % 8;
                        m_pc = stk[m_sp];
                        m_flush = 1;
                    end else begin
                        if (m_kind == 1) m_opt = int'(wreg);
                        m_pc = (m_pc + 1) % 8192;
                    end
                end
                default: ;
            endcase
            m_ph = (m_ph + 1) % 4;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL %s watchdog: actual timeout, expected completion", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk1(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk1("pc", int'(pc), m_pc);
            chk1("option_reg", int'(option_reg), m_opt);
            chk1("gie", int'(gie), m_gie);
            chk1("flush", int'(flush), m_flush);
        end
    end

    task automatic quarter(input logic [13:0] op, input logic [7:0] w,
                           input logic pr, input logic [12:0] pa);
        @(negedge clk);
        instr = op; wreg = w; push_req = pr; push_addr = pa; q_en = 1'b1;
        @(posedge clk);
        #1 model_step();
    endtask

    task automatic idle_clk();
        @(negedge clk);
        q_en = 1'b0; push_req = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic icycle(input logic [13:0] op, input logic [7:0] w,
                          input logic pr, input logic [12:0] pa);
        quarter(op, w, pr, pa);
        quarter(op, w, 1'b0, pa);
        quarter(op, w, 1'b0, pa);
        quarter(op, w, 1'b0, pa);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) stk[i] = 0;
        // R1: reset values while reset is held and just after release
        cmp_on = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        idle_clk();

        cur_req = "R3";
        icycle(14'h0000, 8'h12, 1'b0, '0);
        icycle(14'h0020, 8'h34, 1'b0, '0);
        icycle(14'h0040, 8'h56, 1'b0, '0);
        icycle(14'h0060, 8'h78, 1'b0, '0);

        cur_req = "R4";
        icycle(14'h0062, 8'h5A, 1'b0, '0);
        icycle(14'h0062, 8'h00, 1'b0, '0);

        cur_req = "R5";
        icycle(14'h0063, 8'hC3, 1'b0, '0);
        icycle(14'h0008, 8'hC3, 1'b0, '0);
        icycle(14'h00A0, 8'hC3, 1'b0, '0);
        icycle(14'h3FFF, 8'hC3, 1'b0, '0);

        cur_req = "R2";
        quarter(14'h0062, 8'hA5, 1'b0, '0);
        idle_clk(); idle_clk();
        quarter(14'h0062, 8'hA5, 1'b0, '0);
        idle_clk();
        quarter(14'h0062, 8'hA5, 1'b0, '0);
        idle_clk(); idle_clk(); idle_clk();
        quarter(14'h0062, 8'h3C, 1'b0, '0);
        idle_clk();

        cur_req = "R9";
        icycle(14'h0000, 8'h00, 1'b1, 13'h1234);
        cur_req = "R6";
        icycle(14'h0009, 8'h00, 1'b0, '0);
        cur_req = "R8";
        icycle(14'h0062, 8'h11, 1'b0, '0);
        cur_req = "R7";
        icycle(14'h0000, 8'h00, 1'b0, '0);

        cur_req = "R10";
        for (int i = 0; i < 10; i++) icycle(14'h0000, 8'h00, 1'b1, 13'(16'h0100 + i * 3));
        for (int i = 0; i < 10; i++) begin
            icycle(14'h0009, 8'h00, 1'b0, '0);
            icycle(14'h0009, 8'h00, 1'b0, '0);
        end
        cur_req = "R9";
        icycle(14'h0009, 8'h00, 1'b1, 13'h0ABC);
        icycle(14'h0000, 8'h00, 1'b0, '0);
        idle_clk();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule